// File: doc/BRIEF.md
# Receive Frame Queue with Interrupt-Driven Head Window

This block keeps received frames that have already passed acceptance filtering, in the order they arrived, until a host CPU takes them. The oldest stored frame is always shown on one fixed read window (identifier, control word and data word). The host never changes the location it reads. When it has copied the window, it clears the frames-available interrupt. That clear drops the head frame and moves the next one into the window.

Besides the frames-available line, the block drives two sticky interrupts. One is an almost-full warning, raised when the store grows to a set fill level. The other is an overflow, raised when a frame arrives with no room for it. A refused frame is lost. Later frames keep being refused until the host services the head. The depth, the warning level and all field widths are parameters. The defaults are six slots with the warning at five.

Top module: `rx_frame_queue`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the store and clears `irq_avail`, `irq_warn` and `irq_ovf`.
- R2: Frames leave the window in exactly the order in which they were accepted.
- R3: `win_id`, `win_ctrl` and `win_data` always show the oldest stored frame. They change only when the head is removed.
- R4: `irq_avail` is high in every cycle where at least one frame is stored, and low when the store is empty. It goes high in the cycle after a frame is accepted into an empty store.
- R5: A one-cycle pulse on `clr_avail` while frames are stored removes the head frame. From the next cycle the window shows the following frame, and `irq_avail` stays high if any frame is left.
- R6: A pulse on `clr_avail` while the store is empty has no effect. The store stays empty and no flag changes.
- R7: The store holds at most DEPTH frames (default 6). A frame offered on `in_vld` while DEPTH frames are stored and `clr_avail` is low is discarded. `irq_ovf` is set from the next cycle.
- R8: Frames keep being refused while the store is full. After the host removes one frame, the next offered frame is accepted.
- R9: `irq_warn` is set in the cycle after an accepted frame (with no removal in that cycle) brings the stored count up to WARN_LVL (default 5). It stays set while the count changes. It is cleared only by a high `clr_warn` (write-one-to-clear).
- R10: `irq_ovf` is sticky. Only a high `clr_ovf` clears it.
- R11: A frame offered in the same cycle as a `clr_avail` pulse with the store full is accepted. The head is removed, the count stays at DEPTH and `irq_ovf` is not set.
- R12: If a set event and the matching clear input fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | A filtered frame is offered this cycle |
| in_id | input | ID_W | Identifier of the offered frame |
| in_ctrl | input | CTRL_W | Control word of the offered frame |
| in_data | input | DATA_W | Data word of the offered frame |
| clr_avail | input | 1 | Host clear of the available interrupt; pops the head |
| clr_warn | input | 1 | Write-one-to-clear for the warning flag |
| clr_ovf | input | 1 | Write-one-to-clear for the overflow flag |
| win_id | output | ID_W | Identifier of the head frame |
| win_ctrl | output | CTRL_W | Control word of the head frame |
| win_data | output | DATA_W | Data word of the head frame |
| irq_avail | output | 1 | At least one frame is stored |
| irq_warn | output | 1 | Sticky almost-full warning |
| irq_ovf | output | 1 | Sticky overflow, a frame was discarded |

## Verification
Two cases are driven in the same cycle on purpose. The first is an arriving frame together with a host clear while the store is full. The bench offers a frame and pulses `clr_avail` on the same falling edge. It then expects the old head to be gone, the new frame queued at the tail and no overflow. The scoreboard confirms this by draining the store and checking the order. The second is a flag set event together with its write-one-to-clear. The frame that brings the count to the warning level is sent while `clr_warn` is high, and the warning flag must read as set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // Index of each interrupt flag in the flag vector of the top module.
   typedef enum logic [1:0] {
      FLG_WARN = 2'd0,
      FLG_OVF  = 2'd1
   } rxq_flag_e;

   localparam int unsigned NUM_STICKY = 2;

   // Bits needed for an occupancy counter that can reach 'depth'.
   function automatic int unsigned occ_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

   // Bits needed for a slot pointer over 'depth' slots.
   function automatic int unsigned ptr_bits(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter int unsigned DEPTH = 6
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         push,
   input  logic                         pop,
   input  logic [W-1:0]                 wdata,
   output logic [W-1:0]                 head,
   output logic [occ_bits(DEPTH)-1:0]   count
);
   localparam int unsigned CW   = occ_bits(DEPTH);
   localparam int unsigned PW   = ptr_bits(DEPTH);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   initial begin
      if (DEPTH < 2) $error("rxq_store: DEPTH must be at least 2");
      if (W < 1)     $error("rxq_store: W must be positive");
   end

   logic [PW-1:0] wptr, rptr;
   logic [W-1:0]  slot [DEPTH];

   // One register group per slot, written only when the tail points at it.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && (wptr == PW'(i))) begin
            slot[i] <= wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
         if (pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_comb begin
      head = slot[0];
      for (int j = 1; j < DEPTH; j++) begin
         if (rptr == PW'(j)) head = slot[j];
      end
   end

   p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
      count <= CW'(DEPTH))
      else $error("store count above depth");

   p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
      pop |-> (count != '0))
      else $error("pop issued on empty store");

   p_push_room_r8: assert property (@(posedge clk) disable iff (rst)
      (push && !pop) |-> (count < CW'(DEPTH)))
      else $error("push issued on full store without pop");
endmodule

// File: rtl/rxq_admit.sv
module rxq_admit
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH    = 6,
   parameter int unsigned WARN_LVL = 5
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_vld,
   input  logic                       clr_avail,
   input  logic [occ_bits(DEPTH)-1:0] count,
   output logic                       push_acc,
   output logic                       pop_acc,
   output logic                       warn_evt,
   output logic                       ovf_evt
);
   localparam int unsigned CW = occ_bits(DEPTH);

   initial begin
      if (WARN_LVL < 1 || WARN_LVL > DEPTH)
         $error("rxq_admit: WARN_LVL must lie in 1..DEPTH");
   end

   logic full, empty;

   always_comb begin
      full     = (count == CW'(DEPTH));
      empty    = (count == '0);
      pop_acc  = clr_avail && !empty;
      push_acc = in_vld && (!full || pop_acc);
      ovf_evt  = in_vld && full && !pop_acc;
      warn_evt = push_acc && !pop_acc && (count == CW'(WARN_LVL - 1));
   end

   p_full_swap_r11: assert property (@(posedge clk) disable iff (rst)
      (in_vld && clr_avail && full) |=> (count == CW'(DEPTH)))
      else $error("swap on full store lost a slot");

   p_empty_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (clr_avail && !in_vld && empty) |=> (count == '0))
      else $error("clear on empty store changed count");

   p_pop_step_r5: assert property (@(posedge clk) disable iff (rst)
      (pop_acc && !push_acc) |=> (count == $past(count) - 1'b1))
      else $error("pop did not lower count by one");
endmodule

// File: rtl/rxq_flag.sv
module rxq_flag (
   input  logic clk,
   input  logic rst,
   input  logic set_evt,
   input  logic clr,
   output logic flag
);
   // A set event wins over a write-one-to-clear in the same cycle.
   always_ff @(posedge clk) begin
      if (rst)          flag <= 1'b0;
      else if (set_evt) flag <= 1'b1;
      else if (clr)     flag <= 1'b0;
   end

   p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
      set_evt |=> flag)
      else $error("flag not set after event");

   p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      (flag && !clr) |=> flag)
      else $error("sticky flag dropped without clear");
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
   import rxq_pkg::*;
#(
   parameter int unsigned ID_W     = 29,
   parameter int unsigned CTRL_W   = 16,
   parameter int unsigned DATA_W   = 64,
   parameter int unsigned DEPTH    = 6,
   parameter int unsigned WARN_LVL = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [ID_W-1:0]   in_id,
   input  logic [CTRL_W-1:0] in_ctrl,
   input  logic [DATA_W-1:0] in_data,
   input  logic              clr_avail,
   input  logic              clr_warn,
   input  logic              clr_ovf,
   output logic [ID_W-1:0]   win_id,
   output logic [CTRL_W-1:0] win_ctrl,
   output logic [DATA_W-1:0] win_data,
   output logic              irq_avail,
   output logic              irq_warn,
   output logic              irq_ovf
);
   localparam int unsigned FW = ID_W + CTRL_W + DATA_W;
   localparam int unsigned CW = occ_bits(DEPTH);

   initial begin
      if (ID_W < 1 || CTRL_W < 1 || DATA_W < 1)
         $error("rx_frame_queue: field widths must be positive");
   end

   logic [FW-1:0] in_frame, head_frame;
   logic [CW-1:0] count;
   logic          push_acc, pop_acc, warn_evt, ovf_evt;
   logic [NUM_STICKY-1:0] set_vec, clr_vec, flag_vec;

   assign in_frame = {in_id, in_ctrl, in_data};
   assign {win_id, win_ctrl, win_data} = head_frame;

   rxq_admit #(.DEPTH(DEPTH), .WARN_LVL(WARN_LVL)) u_admit (
      .clk       (clk),
      .rst       (rst),
      .in_vld    (in_vld),
      .clr_avail (clr_avail),
      .count     (count),
      .push_acc  (push_acc),
      .pop_acc   (pop_acc),
      .warn_evt  (warn_evt),
      .ovf_evt   (ovf_evt)
   );

   rxq_store #(.W(FW), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst   (rst),
      .push  (push_acc),
      .pop   (pop_acc),
      .wdata (in_frame),
      .head  (head_frame),
      .count (count)
   );

   assign set_vec[FLG_WARN] = warn_evt;
   assign set_vec[FLG_OVF]  = ovf_evt;
   assign clr_vec[FLG_WARN] = clr_warn;
   assign clr_vec[FLG_OVF]  = clr_ovf;

   for (genvar f = 0; f < NUM_STICKY; f++) begin : g_flag
      rxq_flag u_flag (
         .clk     (clk),
         .rst     (rst),
         .set_evt (set_vec[f]),
         .clr     (clr_vec[f]),
         .flag    (flag_vec[f])
      );
   end

   assign irq_warn  = flag_vec[FLG_WARN];
   assign irq_ovf   = flag_vec[FLG_OVF];
   assign irq_avail = (count != '0);

   p_avail_rise_r4: assert property (@(posedge clk) disable iff (rst)
      (in_vld && !irq_avail) |=> irq_avail)
      else $error("available irq missing after first frame");

   p_head_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (irq_avail && !clr_avail) |=> $stable(head_frame))
      else $error("head window changed without pop");

   p_ovf_raise_r7: assert property (@(posedge clk) disable iff (rst)
      ovf_evt |=> irq_ovf)
      else $error("overflow not raised for refused frame");

   p_warn_raise_r9: assert property (@(posedge clk) disable iff (rst)
      warn_evt |=> irq_warn)
      else $error("warning not raised at fill level");

   p_reset_clean_r1: assert property (@(posedge clk)
      rst |=> (!irq_avail && !irq_warn && !irq_ovf))
      else $error("flags not clear after reset");
endmodule

// File: tb/sim_rx_frame_queue.sv
module sim_rx_frame_queue;
   localparam int ID_W = 29, CTRL_W = 16, DATA_W = 64, DEPTH = 6, WARN_LVL = 5;
   localparam int FW = ID_W + CTRL_W + DATA_W;

   logic clk = 1'b0, rst = 1'b1;
   logic in_vld = 1'b0, clr_avail = 1'b0, clr_warn = 1'b0, clr_ovf = 1'b0;
   logic [ID_W-1:0] in_id = '0;
   logic [CTRL_W-1:0] in_ctrl = '0;
   logic [DATA_W-1:0] in_data = '0;
   logic [ID_W-1:0] win_id;
   logic [CTRL_W-1:0] win_ctrl;
   logic [DATA_W-1:0] win_data;
   logic irq_avail, irq_warn, irq_ovf;

   always #2 clk = ~clk;

   rx_frame_queue #(.ID_W(ID_W), .CTRL_W(CTRL_W), .DATA_W(DATA_W),
                    .DEPTH(DEPTH), .WARN_LVL(WARN_LVL)) u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_id(in_id), .in_ctrl(in_ctrl),
      .in_data(in_data), .clr_avail(clr_avail), .clr_warn(clr_warn),
      .clr_ovf(clr_ovf), .win_id(win_id), .win_ctrl(win_ctrl),
      .win_data(win_data), .irq_avail(irq_avail), .irq_warn(irq_warn),
      .irq_ovf(irq_ovf)
   );

   int total = 0, bad = 0;
   bit finished = 0;
   logic [FW-1:0] sb[$];
   logic exp_warn = 0, exp_ovf = 0;

   function automatic logic [FW-1:0] mk(input int k);
      return {ID_W'(32'h0100_0000 + k * 37), CTRL_W'(16'h8000 ^ k),
              DATA_W'(64'hA5A5_0000_0000_0000) | DATA_W'(k * 1234567)};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [FW-1:0] act, input logic [FW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic flags(input string req);
      chk(req, "irq_avail", FW'(irq_avail), FW'(sb.size() != 0));
      chk(req, "irq_warn", FW'(irq_warn), FW'(exp_warn));
      chk(req, "irq_ovf", FW'(irq_ovf), FW'(exp_ovf));
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
      sb.delete(); exp_warn = 0; exp_ovf = 0;
   endtask

   // Driver: offer one frame, optionally with clr_warn in the same cycle.
   task automatic push(input int k, input bit cw);
      @(negedge clk);
      {in_id, in_ctrl, in_data} = mk(k);
      in_vld = 1'b1; clr_warn = cw;
      @(negedge clk);
      in_vld = 1'b0; clr_warn = 1'b0;
      if (sb.size() < DEPTH) begin
         sb.push_back(mk(k));
         if (sb.size() == WARN_LVL) exp_warn = 1;
         else if (cw) exp_warn = 0;
      end else begin
         exp_ovf = 1;
         if (cw) exp_warn = 0;
      end
   endtask

   // Monitor: compare the window with the oldest expected frame, then clear.
   task automatic serve(input string req);
      @(negedge clk);
      chk(req, "avail before pop", FW'(irq_avail), FW'(sb.size() != 0));
      if (sb.size() != 0) chk(req, "window", {win_id, win_ctrl, win_data}, sb[0]);
      clr_avail = 1'b1;
      @(negedge clk);
      clr_avail = 1'b0;
      if (sb.size() != 0) void'(sb.pop_front());
   endtask

   task automatic swap(input int k);
      @(negedge clk);
      chk("R11", "window before swap", {win_id, win_ctrl, win_data}, sb[0]);
      {in_id, in_ctrl, in_data} = mk(k);
      in_vld = 1'b1; clr_avail = 1'b1;
      @(negedge clk);
      in_vld = 1'b0; clr_avail = 1'b0;
      void'(sb.pop_front()); sb.push_back(mk(k));
   endtask

   task automatic wclear(input bit w, input bit o);
      @(negedge clk); clr_warn = w; clr_ovf = o;
      @(negedge clk); clr_warn = 1'b0; clr_ovf = 1'b0;
      if (w) exp_warn = 0;
      if (o) exp_ovf = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      flags("R1");

      // R6: clear on empty store
      serve("R6");
      @(negedge clk);
      flags("R6");

      // R2 R3 R4 R5: short burst in, drained in order
      push(1, 0); flags("R4");
      push(2, 0); push(3, 0);
      serve("R5"); chk("R5", "avail stays", FW'(irq_avail), 1);
      serve("R3"); serve("R2");
      @(negedge clk); flags("R4");

      // R9 R7 R8: fill to depth, then overflow
      for (int k = 10; k < 14; k++) push(k, 0);
      chk("R9", "no warn below level", FW'(irq_warn), 0);
      push(14, 0); flags("R9");
      push(15, 0); flags("R7");
      push(16, 0); flags("R7");
      push(17, 0); flags("R8");
      chk("R7", "head kept", {win_id, win_ctrl, win_data}, mk(10));
      serve("R9"); flags("R9");
      push(18, 0); flags("R8");
      wclear(0, 1); flags("R10");
      wclear(1, 0); flags("R9");

      // R11: push and pop together while full
      swap(19); flags("R11");
      chk("R11", "new head", {win_id, win_ctrl, win_data}, mk(12));
      while (sb.size() != 0) serve("R2");
      @(negedge clk); flags("R2");

      // R12: warning set and clear in the same cycle
      for (int k = 30; k < 34; k++) push(k, 0);
      push(34, 1); flags("R12");
      push(35, 0); push(36, 1); flags("R12");

      // R1: reset while loaded
      do_reset();
      @(negedge clk); flags("R1");
      push(40, 0); serve("R1");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule